// File: doc/BRIEF.md
# Overlap-Safe Rectangle Copy Setup Unit

This unit prepares a screen-to-screen rectangle copy for a 2D drawing engine. It takes one request holding the source corner, the destination corner, the width, the height and a packed-24-bit pixel flag. It returns the start corners, the size word and a control word for the engine.

For each axis, the unit picks the traversal direction so that a copy whose source and destination overlap never reads a pixel it has already overwritten. When it starts from the far edge, it moves both start corners to that edge. In packed 24-bit mode the engine works in byte units, so every horizontal quantity is tripled. The control word then also carries a byte-rotation phase, taken modulo 6, which the engine uses to realign three-byte pixels.

Requests arrive on a single-cycle strobe. The unit accepts a request in every cycle and applies no back-pressure, so no ready signal exists. The results are registered and held until the next accepted request. A one-cycle `done` pulse marks each new result.

Top module: `blit_setup`

## Requirements
- R1: After reset, `src_xy`, `dst_xy`, `size_wh` and `ctl_word` are zero, and `dropped` and `done` are low.
- R2: When `mode24` is high, source x, destination x and width are multiplied by 3 before any other step. The y values and the height are never scaled.
- R3: If source y is less than destination y, height-1 is added to both y values and `ctl_word` bit 1 (top-to-bottom) is 0. Otherwise the y values are unchanged and bit 1 is 1.
- R4: The scaled x values are compared. If source x is less than destination x, scaled width-1 is added to both x values and `ctl_word` bit 0 (left-to-right) is 0. Otherwise the x values are unchanged and bit 0 is 1.
- R5: When `mode24` is high, `ctl_word` bit 7 is 1 and bits [10:8] hold the rotation phase. The phase is (dx/4) mod 6 when bit 0 is 1, and ((dx+2)/4) mod 6 when bit 0 is 0, where dx is the final destination x. When `mode24` is low, bits [10:7] are 0.
- R6: `src_xy` and `dst_xy` hold the final x in bits [31:16] and the final y in bits [15:0], each truncated to 16 bits. `size_wh` holds the scaled width in bits [31:16] and the height in bits [15:0].
- R7: A request with zero width or zero height is dropped. `dropped` goes high, `done` stays low, and the four result words keep their previous values.
- R8: `ctl_word` bit 5 (draw last pixel) is 1 in every accepted result. All `ctl_word` bits not named in R3, R4, R5 or R8 are 0.
- R9: The results and the `done` pulse appear on the clock edge that samples `req_valid`. `done` is high for exactly the cycle after each accepted request. With no request, every output keeps its value and `done` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, sampled each rising edge |
| mode24 | input | 1 | Packed 24-bit pixel mode |
| src_x | input | 16 | Source left x in pixels |
| src_y | input | 16 | Source top y |
| dst_x | input | 16 | Destination left x in pixels |
| dst_y | input | 16 | Destination top y |
| width | input | 16 | Width in pixels |
| height | input | 16 | Height in lines |
| src_xy | output | 32 | Source start corner {x, y} |
| dst_xy | output | 32 | Destination start corner {x, y} |
| size_wh | output | 32 | Size {width, height} |
| ctl_word | output | 16 | Direction, last-pixel and rotation control |
| dropped | output | 1 | Last request was dropped as empty |
| done | output | 1 | One-cycle pulse for a new result |

## Verification
Each result is registered once, so a wrong direction decision, scaling step or phase shows up as a mismatched field one cycle after the strobe. A fault cannot hide in later cycles, because the outputs only hold. A bad comparison at an overlap boundary, where the x or y values are equal, or off by one, flips a direction bit and shifts both start corners by the size minus one. A wrong phase offset changes bits [10:8] only for destination positions near a multiple of 4. Faults in holding or in the strobe path appear on the idle cycle that follows each request, as a stale `done` or a changed word.

// File: rtl/blit_pkg.sv
package blit_pkg;
  localparam int CTL_W      = 16;
  localparam int CTL_LTR    = 0;
  localparam int CTL_TTB    = 1;
  localparam int CTL_LAST   = 5;
  localparam int CTL_ROT_EN = 7;
  localparam int CTL_PH_LO  = 8;
  localparam int PH_W       = 3;
endpackage

// File: rtl/blit_unit_scale.sv
module blit_unit_scale #(
  parameter int CW = 16,
  parameter int XW = CW + 3
) (
  input  logic [CW-1:0] val_i,
  input  logic          triple_i,
  output logic [XW-1:0] val_o
);
  logic [XW-1:0] wide;
  assign wide  = XW'(val_i);
  assign val_o = triple_i ? (wide + (wide << 1)) : wide;
endmodule

// File: rtl/blit_axis_order.sv
module blit_axis_order #(
  parameter int XW = 19
) (
  input  logic [XW-1:0] src_i,
  input  logic [XW-1:0] dst_i,
  input  logic [XW-1:0] len_i,
  output logic [XW-1:0] src_o,
  output logic [XW-1:0] dst_o,
  output logic          fwd_o
);
  logic [XW-1:0] span;
  assign span  = len_i - XW'(1);
  assign fwd_o = !(src_i < dst_i);
  assign src_o = fwd_o ? src_i : src_i + span;
  assign dst_o = fwd_o ? dst_i : dst_i + span;
endmodule

// File: rtl/blit_rot_phase.sv
module blit_rot_phase #(
  parameter int XW = 19
) (
  input  logic [XW-1:0] dx_i,
  input  logic          fwd_i,
  output logic [2:0]    phase_o
);
  logic [XW-1:0] base;
  logic [XW-1:0] quad;
  assign base    = fwd_i ? dx_i : dx_i + XW'(2);
  assign quad    = base >> 2;
  assign phase_o = 3'(quad % XW'(6));
endmodule

// File: rtl/blit_setup.sv
module blit_setup #(
  parameter int CW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic            mode24,
  input  logic [CW-1:0]   src_x,
  input  logic [CW-1:0]   src_y,
  input  logic [CW-1:0]   dst_x,
  input  logic [CW-1:0]   dst_y,
  input  logic [CW-1:0]   width,
  input  logic [CW-1:0]   height,
  output logic [2*CW-1:0] src_xy,
  output logic [2*CW-1:0] dst_xy,
  output logic [2*CW-1:0] size_wh,
  output logic [15:0]     ctl_word,
  output logic            dropped,
  output logic            done
);
  import blit_pkg::*;
  localparam int XW = CW + 3;
  localparam int NSC = 3;

  logic [CW-1:0] sc_in  [NSC];
  logic [XW-1:0] sc_out [NSC];
  assign sc_in[0] = src_x;
  assign sc_in[1] = dst_x;
  assign sc_in[2] = width;

  for (genvar g = 0; g < NSC; g++) begin : g_scale
    blit_unit_scale #(.CW(CW), .XW(XW)) u_scale (
      .val_i(sc_in[g]), .triple_i(mode24), .val_o(sc_out[g])
    );
  end

  logic [XW-1:0] fx_src, fx_dst, fy_src, fy_dst;
  logic          x_fwd, y_fwd;

  blit_axis_order #(.XW(XW)) u_xord (
    .src_i(sc_out[0]), .dst_i(sc_out[1]), .len_i(sc_out[2]),
    .src_o(fx_src), .dst_o(fx_dst), .fwd_o(x_fwd)
  );

  blit_axis_order #(.XW(XW)) u_yord (
    .src_i(XW'(src_y)), .dst_i(XW'(dst_y)), .len_i(XW'(height)),
    .src_o(fy_src), .dst_o(fy_dst), .fwd_o(y_fwd)
  );

  logic [PH_W-1:0] phase;
  blit_rot_phase #(.XW(XW)) u_rot (
    .dx_i(fx_dst), .fwd_i(x_fwd), .phase_o(phase)
  );

  logic        empty;
  logic [15:0] ctl_next;
  assign empty = (width == '0) || (height == '0);

  always_comb begin
    ctl_next           = '0;
    ctl_next[CTL_LTR]  = x_fwd;
    ctl_next[CTL_TTB]  = y_fwd;
    ctl_next[CTL_LAST] = 1'b1;
    if (mode24) begin
      ctl_next[CTL_ROT_EN]                  = 1'b1;
      ctl_next[CTL_PH_LO +: PH_W]           = phase;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_xy   <= '0;
      dst_xy   <= '0;
      size_wh  <= '0;
      ctl_word <= '0;
      dropped  <= 1'b0;
      done     <= 1'b0;
    end else begin
      done <= req_valid && !empty;
      if (req_valid) dropped <= empty;
      if (req_valid && !empty) begin
        src_xy   <= {fx_src[CW-1:0], fy_src[CW-1:0]};
        dst_xy   <= {fx_dst[CW-1:0], fy_dst[CW-1:0]};
        size_wh  <= {sc_out[2][CW-1:0], height};
        ctl_word <= ctl_next;
      end
    end
  end

  AST_DROP_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && empty) |=> (dropped && !done)); // R7
  AST_DROP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && empty) |=> ($stable(src_xy) && $stable(dst_xy) && $stable(size_wh))); // R7
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!done && $stable(ctl_word) && $stable(dst_xy) && $stable(dropped))); // R9
  AST_LAST_PEL: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ctl_word[CTL_LAST]); // R8
  AST_ROT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !empty && !mode24) |=> (ctl_word[10:7] == 4'd0)); // R5
  AST_ROT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (ctl_word[10:8] < 3'd6)); // R5
  AST_Y_UNSCALED: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !empty) |=> (size_wh[CW-1:0] == $past(height))); // R2
endmodule

// File: tb/blit_setup_bench.sv
module blit_setup_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, mode24 = 1'b0;
  logic [15:0] src_x = '0, src_y = '0, dst_x = '0, dst_y = '0, width = '0, height = '0;
  logic [31:0] src_xy, dst_xy, size_wh;
  logic [15:0] ctl_word;
  logic dropped, done;
  int checks = 0, errors = 0;
  logic [31:0] e_src = '0, e_dst = '0, e_size = '0;
  logic [15:0] e_ctl = '0;

  always #10 clk = ~clk;

  blit_setup u_blit_setup (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .mode24(mode24),
    .src_x(src_x), .src_y(src_y), .dst_x(dst_x), .dst_y(dst_y),
    .width(width), .height(height), .src_xy(src_xy), .dst_xy(dst_xy),
    .size_wh(size_wh), .ctl_word(ctl_word), .dropped(dropped), .done(done)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_words(input string tag);
    chk(src_xy == e_src, {tag, " R6 src_xy R2 R3 R4"}, src_xy, e_src);
    chk(dst_xy == e_dst, {tag, " R6 dst_xy R2 R3 R4"}, dst_xy, e_dst);
    chk(size_wh == e_size, {tag, " R6 size_wh R2"}, size_wh, e_size);
    chk(ctl_word == e_ctl, {tag, " R3 R4 R5 R8 ctl_word"}, {16'h0, ctl_word}, {16'h0, e_ctl});
  endtask

  task automatic do_req(input int sx, input int sy, input int dx, input int dy,
                        input int w, input int h, input bit m);
    int xs, xd, ws, ys, yd, ph;
    bit ltr, ttb, emp;
    emp = (w == 0) || (h == 0);
    xs = m ? sx * 3 : sx; xd = m ? dx * 3 : dx; ws = m ? w * 3 : w;
    ys = sy; yd = dy;
    if (sy < dy) begin ys += h - 1; yd += h - 1; ttb = 0; end else ttb = 1;
    if (xs < xd) begin xs += ws - 1; xd += ws - 1; ltr = 0; end else ltr = 1;
    ph = m ? (ltr ? (xd / 4) % 6 : ((xd + 2) / 4) % 6) : 0;
    @(negedge clk);
    req_valid = 1'b1; mode24 = m;
    src_x = 16'(sx); src_y = 16'(sy); dst_x = 16'(dx); dst_y = 16'(dy);
    width = 16'(w); height = 16'(h);
    @(negedge clk);
    req_valid = 1'b0;
    if (!emp) begin
      e_src  = {xs[15:0], ys[15:0]};
      e_dst  = {xd[15:0], yd[15:0]};
      e_size = {ws[15:0], h[15:0]};
      e_ctl  = 16'(ltr) | (16'(ttb) << 1) | 16'h0020 | (16'(m) << 7) | (16'(ph) << 8);
    end
    chk(done == !emp, "R9 R7 done after request", {31'h0, done}, {31'h0, !emp});
    chk(dropped == emp, "R7 dropped flag", {31'h0, dropped}, {31'h0, emp});
    check_words(emp ? "R7 hold" : "accept");
    @(negedge clk);
    chk(done == 1'b0, "R9 done one cycle", {31'h0, done}, 32'h0);
    check_words("R9 idle hold");
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    chk(src_xy == 0 && dst_xy == 0 && size_wh == 0, "R1 reset words", src_xy | dst_xy | size_wh, 32'h0);
    chk(ctl_word == 0 && !dropped && !done, "R1 reset ctl/flags", {14'h0, dropped, done, ctl_word}, 32'h0);
    rst_n = 1'b1;
    for (int m = 0; m < 2; m++)
      for (int sx = 0; sx < 6; sx++)
        for (int dx = 0; dx < 6; dx++)
          for (int sy = 0; sy < 3; sy++)
            for (int dy = 0; dy < 3; dy++)
              for (int w = 0; w < 4; w++)
                for (int h = 0; h < 3; h++)
                  do_req(sx, sy, dx, dy, w, h, bit'(m));
    do_req(1000, 40, 1003, 7, 57, 9, 1'b1);
    do_req(60000, 300, 100, 301, 1000, 5, 1'b1);
    do_req(65535, 2, 65530, 2, 65535, 65535, 1'b0);
    do_req(3, 4, 9, 8, 0, 5, 1'b1);
    do_req(21, 0, 22, 0, 2, 1, 1'b1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule